// File: doc/BRIEF.md
# Verified Result Reuse Buffer

This block sits beside the issue logic of a core that runs every instruction twice for soft-error detection. It keeps a small, fully associative set of instructions whose two executions have already been compared and found equal, each stored as an opcode, two source operand values and the agreed result.

When the leading copy of an instruction executes, the issue logic presents its opcode and operand values on the lookup port. The answer comes back in the same cycle. On a hit, the stored result is returned and the hit flag tells the issue logic that the trailing copy need not be issued. On a miss, both copies are issued as usual.

Once the comparison stage has seen two copies agree, it offers the instruction on the insert port. A key that is already stored has its result refreshed in its slot. A new key takes the slot named by a round-robin pointer. A clear input empties the whole buffer.

Top module: `chk_reuse_cache`

## Requirements
- R1: After reset, every slot is empty, so any lookup returns lk_hit = 0 and lk_result = 0.
- R2: A lookup hits only when a valid slot holds exactly the same opcode, first operand and second operand. On a hit, lk_hit = 1 and lk_result carries the stored result in the same cycle, so the second issue can be skipped.
- R3: A lookup that differs from every stored key in any one of the three fields misses, with lk_hit = 0 and lk_result = 0.
- R4: An insert is written only when ins_valid = 1 and ins_agree = 1. An insert with ins_agree = 0 leaves the buffer unchanged.
- R5: An accepted insert becomes visible to lookups from the clock edge that samples it. A lookup in that same cycle sees the old contents.
- R6: Inserting a key that is already stored replaces that slot's result. It uses no new slot and does not move the replacement pointer.
- R7: New keys fill slots in round-robin order. Once all ENTRIES slots are in use, the next new key evicts the slot that was filled longest ago, wrapping from ENTRIES-1 to 0.
- R8: clr_all = 1 empties every slot at the next edge and returns the pointer to slot 0. An insert offered in the same cycle as a clear is discarded.
- R9: With lk_valid = 0, lk_hit = 0 and lk_result = 0, whatever the lookup operands are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_all | input | 1 | Invalidate all slots |
| lk_valid | input | 1 | Lookup request |
| lk_opc | input | OPC_W | Lookup opcode |
| lk_src_a | input | DATA_W | Lookup first operand value |
| lk_src_b | input | DATA_W | Lookup second operand value |
| lk_hit | output | 1 | Stored verified result found; second issue may be skipped |
| lk_result | output | DATA_W | Stored result on a hit, zero otherwise |
| ins_valid | input | 1 | Insert request |
| ins_agree | input | 1 | Both executions matched |
| ins_opc | input | OPC_W | Insert opcode |
| ins_src_a | input | DATA_W | Insert first operand value |
| ins_src_b | input | DATA_W | Insert second operand value |
| ins_result | input | DATA_W | Agreed result to store |

## Verification
The bench builds the buffer with ENTRIES = 5, OPC_W = 6 and DATA_W = 16. Five slots is not a power of two, so the pointer wrap from slot 4 back to 0 is tested on a modulo path rather than a natural rollover. A short run can also fill the buffer, evict from it and then evict again. The narrow fields keep the near-miss keys easy to read: each one differs from a stored key in one field only.

// File: rtl/reuse_pkg.sv
package reuse_pkg;

  // what an insert request does to the storage
  typedef enum logic [1:0] {
    INS_NONE   = 2'd0,
    INS_UPDATE = 2'd1,
    INS_ALLOC  = 2'd2
  } ins_act_e;

endpackage

// File: rtl/reuse_match.sv
// Parallel key comparison against every slot.
module reuse_match #(
  parameter int ENTRIES = 8,
  parameter int KEY_W   = 72
) (
  input  logic               req,
  input  logic [KEY_W-1:0]   probe,
  input  logic [ENTRIES-1:0] slot_vld,
  input  logic [KEY_W-1:0]   slot_key [ENTRIES],
  output logic [ENTRIES-1:0] hit_vec,
  output logic               hit_any
);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = req && slot_vld[g] && (slot_key[g] == probe);
  end

  assign hit_any = |hit_vec;

endmodule

// File: rtl/reuse_enc.sv
// One-hot to binary index.
module reuse_enc #(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 3
) (
  input  logic [ENTRIES-1:0] onehot,
  output logic [IDX_W-1:0]   idx
);

  always_comb begin
    idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (onehot[i]) idx = idx | IDX_W'(i);
    end
  end

endmodule

// File: rtl/reuse_victim.sv
// Round-robin slot pointer for new allocations.
module reuse_victim #(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             adv,
  output logic [IDX_W-1:0] ptr
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ptr <= '0;
    end else if (adv) begin
      ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
  end

endmodule

// File: rtl/chk_reuse_cache.sv
// Fully associative buffer of verified instruction results.
module chk_reuse_cache
  import reuse_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int OPC_W   = 8,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_all,
  input  logic              lk_valid,
  input  logic [OPC_W-1:0]  lk_opc,
  input  logic [DATA_W-1:0] lk_src_a,
  input  logic [DATA_W-1:0] lk_src_b,
  output logic              lk_hit,
  output logic [DATA_W-1:0] lk_result,
  input  logic              ins_valid,
  input  logic              ins_agree,
  input  logic [OPC_W-1:0]  ins_opc,
  input  logic [DATA_W-1:0] ins_src_a,
  input  logic [DATA_W-1:0] ins_src_b,
  input  logic [DATA_W-1:0] ins_result
);

  localparam int KEY_W = OPC_W + 2 * DATA_W;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] valid_q;
  logic [KEY_W-1:0]   key_q [ENTRIES];
  logic [DATA_W-1:0]  res_q [ENTRIES];

  logic [KEY_W-1:0]   lk_key, ins_key;
  logic [ENTRIES-1:0] lk_vec, ins_vec;
  logic               lk_any, ins_any;
  logic [IDX_W-1:0]   lk_idx, ins_idx, vic_ptr;
  logic               ins_ok;
  ins_act_e           act;

  assign lk_key  = {lk_opc, lk_src_a, lk_src_b};
  assign ins_key = {ins_opc, ins_src_a, ins_src_b};
  assign ins_ok  = ins_valid && ins_agree && !clr_all;

  reuse_match #(.ENTRIES(ENTRIES), .KEY_W(KEY_W)) u_lk_match (
    .req(lk_valid), .probe(lk_key), .slot_vld(valid_q), .slot_key(key_q),
    .hit_vec(lk_vec), .hit_any(lk_any)
  );

  reuse_match #(.ENTRIES(ENTRIES), .KEY_W(KEY_W)) u_ins_match (
    .req(ins_ok), .probe(ins_key), .slot_vld(valid_q), .slot_key(key_q),
    .hit_vec(ins_vec), .hit_any(ins_any)
  );

  reuse_enc #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_lk_enc (
    .onehot(lk_vec), .idx(lk_idx)
  );

  reuse_enc #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_ins_enc (
    .onehot(ins_vec), .idx(ins_idx)
  );

  always_comb begin
    if (!ins_ok)      act = INS_NONE;
    else if (ins_any) act = INS_UPDATE;
    else              act = INS_ALLOC;
  end

  reuse_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .clk(clk), .rst(rst), .clr(clr_all),
    .adv(act == INS_ALLOC), .ptr(vic_ptr)
  );

  // valid bits: reset and clear
  always_ff @(posedge clk) begin
    if (rst || clr_all) begin
      valid_q <= '0;
    end else if (act == INS_ALLOC) begin
      valid_q[vic_ptr] <= 1'b1;
    end
  end

  // key and result storage, no reset
  always_ff @(posedge clk) begin
    if (!rst) begin
      case (act)
        INS_ALLOC: begin
          key_q[vic_ptr] <= ins_key;
          res_q[vic_ptr] <= ins_result;
        end
        INS_UPDATE: res_q[ins_idx] <= ins_result;
        default: ;
      endcase
    end
  end

  assign lk_hit    = lk_any;
  assign lk_result = lk_any ? res_q[lk_idx] : '0;

endmodule

// File: rtl/reuse_cache_chk.sv
module reuse_cache_chk #(
  parameter int ENTRIES = 8,
  parameter int OPC_W   = 8,
  parameter int DATA_W  = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               clr_all,
  input logic               lk_valid,
  input logic [OPC_W-1:0]   lk_opc,
  input logic [DATA_W-1:0]  lk_src_a,
  input logic [DATA_W-1:0]  lk_src_b,
  input logic               lk_hit,
  input logic [DATA_W-1:0]  lk_result,
  input logic               ins_valid,
  input logic               ins_agree,
  input logic [OPC_W-1:0]   ins_opc,
  input logic [DATA_W-1:0]  ins_src_a,
  input logic [DATA_W-1:0]  ins_src_b,
  input logic [DATA_W-1:0]  ins_result,
  input logic [ENTRIES-1:0] valid_q,
  input logic [ENTRIES-1:0] lk_vec
);

  // R6
  no_dup_key_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_vec));

  // R8
  clear_empties_chk: assert property (@(posedge clk) disable iff (rst)
    clr_all |=> !lk_hit);

  // R5
  insert_visible_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(ins_valid && ins_agree && !clr_all) && lk_valid &&
     lk_opc == $past(ins_opc) && lk_src_a == $past(ins_src_a) &&
     lk_src_b == $past(ins_src_b))
    |-> (lk_hit && lk_result == $past(ins_result)));

  // R3
  miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !lk_hit |-> (lk_result == '0));

  // R9
  idle_no_hit_chk: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |-> !lk_hit);

  // R4
  disagree_no_grow_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr_all && !(ins_valid && ins_agree)) |=> $stable(valid_q));

endmodule

bind chk_reuse_cache reuse_cache_chk #(
  .ENTRIES(ENTRIES), .OPC_W(OPC_W), .DATA_W(DATA_W)
) i_chk (
  .clk(clk), .rst(rst), .clr_all(clr_all), .lk_valid(lk_valid),
  .lk_opc(lk_opc), .lk_src_a(lk_src_a), .lk_src_b(lk_src_b),
  .lk_hit(lk_hit), .lk_result(lk_result), .ins_valid(ins_valid),
  .ins_agree(ins_agree), .ins_opc(ins_opc), .ins_src_a(ins_src_a),
  .ins_src_b(ins_src_b), .ins_result(ins_result),
  .valid_q(valid_q), .lk_vec(lk_vec)
);

// File: tb/test_chk_reuse_cache.sv
`timescale 1ns/1ps
module test_chk_reuse_cache;
  localparam int N  = 5;
  localparam int OW = 6;
  localparam int DW = 16;

  logic clk = 0, rst = 1, clr_all = 0;
  logic lk_valid = 0, ins_valid = 0, ins_agree = 0;
  logic [OW-1:0] lk_opc = '0, ins_opc = '0;
  logic [DW-1:0] lk_src_a = '0, lk_src_b = '0, ins_src_a = '0, ins_src_b = '0, ins_result = '0;
  logic lk_hit;
  logic [DW-1:0] lk_result;

  int checks = 0, fails = 0, cycles = 0;

  typedef struct {
    logic          hit;
    logic [DW-1:0] res;
    string         tag;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  chk_reuse_cache #(.ENTRIES(N), .OPC_W(OW), .DATA_W(DW)) i_chk_reuse_cache (
    .clk(clk), .rst(rst), .clr_all(clr_all), .lk_valid(lk_valid),
    .lk_opc(lk_opc), .lk_src_a(lk_src_a), .lk_src_b(lk_src_b),
    .lk_hit(lk_hit), .lk_result(lk_result), .ins_valid(ins_valid),
    .ins_agree(ins_agree), .ins_opc(ins_opc), .ins_src_a(ins_src_a),
    .ins_src_b(ins_src_b), .ins_result(ins_result)
  );

  // monitor: compare at the falling edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (lk_hit !== e.hit || lk_result !== e.res) begin
        fails++;
        $display("FAIL %s: hit=%0b result=%0h expected hit=%0b result=%0h",
                 e.tag, lk_hit, lk_result, e.hit, e.res);
      end
    end
  end

  task automatic look(input logic v, input logic [OW-1:0] o,
                      input logic [DW-1:0] a, input logic [DW-1:0] b,
                      input logic eh, input logic [DW-1:0] er, input string tag);
    exp_t e;
    lk_valid = v; lk_opc = o; lk_src_a = a; lk_src_b = b;
    e.hit = eh; e.res = er; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic ins(input logic ag, input logic [OW-1:0] o,
                     input logic [DW-1:0] a, input logic [DW-1:0] b,
                     input logic [DW-1:0] r);
    ins_valid = 1; ins_agree = ag; ins_opc = o;
    ins_src_a = a; ins_src_b = b; ins_result = r;
  endtask

  task automatic cycle();
    @(posedge clk); #1;
    lk_valid = 0; ins_valid = 0; clr_all = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 20000) begin
      checks++; fails++;
      $display("FAIL watchdog: cycles=%0d expected below 20000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R1 empty after reset
    look(1, 6'd0, 16'd0, 16'd0, 0, 16'd0, "R1 zero key"); cycle();
    look(1, 6'd1, 16'd2, 16'd3, 0, 16'd0, "R1 any key"); cycle();
    // R5 insert, lookup in the same cycle sees the old contents
    ins(1, 6'd1, 16'd10, 16'd20, 16'h100);
    look(1, 6'd1, 16'd10, 16'd20, 0, 16'd0, "R5 same cycle"); cycle();
    look(1, 6'd1, 16'd10, 16'd20, 1, 16'h100, "R2 R5 next cycle hit"); cycle();
    // R3 near misses
    look(1, 6'd1, 16'd10, 16'd21, 0, 16'd0, "R3 src_b differs"); cycle();
    look(1, 6'd2, 16'd10, 16'd20, 0, 16'd0, "R3 opcode differs"); cycle();
    look(1, 6'd1, 16'd11, 16'd20, 0, 16'd0, "R3 src_a differs"); cycle();
    // R4 disagree dropped
    ins(0, 6'd3, 16'd5, 16'd6, 16'h7); cycle();
    look(1, 6'd3, 16'd5, 16'd6, 0, 16'd0, "R4 disagree dropped"); cycle();
    // R6 update in place
    ins(1, 6'd1, 16'd10, 16'd20, 16'h111); cycle();
    look(1, 6'd1, 16'd10, 16'd20, 1, 16'h111, "R6 updated result"); cycle();
    // fill the remaining four slots
    for (int k = 0; k < 4; k++) begin
      ins(1, 6'(4 + k), 16'(k), 16'(k), 16'(16'h200 + k)); cycle();
    end
    look(1, 6'd1, 16'd10, 16'd20, 1, 16'h111, "R6 no slot consumed"); cycle();
    look(1, 6'd7, 16'd3, 16'd3, 1, 16'h203, "R7 last slot"); cycle();
    // R7 fifth new key evicts oldest (first key)
    ins(1, 6'd8, 16'd4, 16'd4, 16'h204); cycle();
    look(1, 6'd1, 16'd10, 16'd20, 0, 16'd0, "R7 oldest evicted"); cycle();
    look(1, 6'd4, 16'd0, 16'd0, 1, 16'h200, "R7 second kept"); cycle();
    look(1, 6'd8, 16'd4, 16'd4, 1, 16'h204, "R7 new key present"); cycle();
    ins(1, 6'd9, 16'd5, 16'd5, 16'h205); cycle();
    look(1, 6'd4, 16'd0, 16'd0, 0, 16'd0, "R7 next eviction"); cycle();
    look(1, 6'd5, 16'd1, 16'd1, 1, 16'h201, "R7 third kept"); cycle();
    // R9 idle lookup with a stored key
    look(0, 6'd5, 16'd1, 16'd1, 0, 16'd0, "R9 lk_valid low"); cycle();
    // R8 clear beats simultaneous insert
    clr_all = 1; ins(1, 6'd12, 16'd7, 16'd7, 16'h300); cycle();
    look(1, 6'd5, 16'd1, 16'd1, 0, 16'd0, "R8 cleared entry"); cycle();
    look(1, 6'd12, 16'd7, 16'd7, 0, 16'd0, "R8 insert dropped"); cycle();
    // R8 clear restarts the pointer: five fresh keys, the sixth evicts the first
    for (int k = 0; k < 6; k++) begin
      ins(1, 6'(20 + k), 16'(k), 16'd1, 16'(16'h400 + k)); cycle();
    end
    look(1, 6'd20, 16'd0, 16'd1, 0, 16'd0, "R7 R8 refill eviction"); cycle();
    look(1, 6'd21, 16'd1, 16'd1, 1, 16'h401, "R8 refill kept"); cycle();
    cycle();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule